// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This is a purely combinational shift unit for the operand path of a 32-bit RISC core. It moves an operand left or right by an 8-bit amount, or rotates it right. It also produces a carry-out bit, which the flag logic downstream may latch. All four shift kinds take the full amount range from 0 to 255. The carry-out obeys the architectural rules for amounts of zero, exactly the word width, and beyond the word width.

An amount of zero does not always mean "no shift". For a logical left shift it passes the operand and the carry-in through unchanged. For both right shifts it stands for a shift by the full word width. For a rotate it becomes a one-bit rotate through the carry. The selection between a register amount and an immediate amount is made upstream. Flag updates are made downstream.

The word width must be a power of two.

Top module: `shift_unit`

## Requirements
- R1: With kind 2'b00 (logical left) and an amount n from 1 to 32, the result is the operand shifted left by n with zeros filled in, and carry-out is operand bit 32-n (for n = 32 this gives result 0 and carry-out equal to bit 0).
- R2: With kind 2'b00 and an amount of 0, the result equals the operand and carry-out equals carry-in.
- R3: With kind 2'b00 and an amount above 32, the result is 0 and carry-out is 0.
- R4: With kind 2'b01 (logical right) and an amount n from 1 to 32, the result is the operand shifted right by n with zeros filled in, and carry-out is operand bit n-1 (for n = 32 this gives result 0 and carry-out equal to bit 31).
- R5: With kind 2'b01 and an amount of 0, the outputs equal those for an amount of 32.
- R6: With kind 2'b01 and an amount above 32, the result is 0 and carry-out is 0.
- R7: With kind 2'b10 (arithmetic right) and an amount n from 1 to 31, the result is the operand shifted right by n with copies of bit 31 filled in, and carry-out is operand bit n-1.
- R8: With kind 2'b10 and an amount of 0 or of 32 and above, every result bit equals operand bit 31, and carry-out equals operand bit 31.
- R9: With kind 2'b11 (rotate right) and a nonzero amount that is not a multiple of 32, the result is the operand rotated right by the amount modulo 32, and carry-out equals result bit 31.
- R10: With kind 2'b11 and a nonzero amount that is a multiple of 32, the result equals the operand and carry-out equals operand bit 31.
- R11: With kind 2'b11 and an amount of 0, the result is {carry-in, operand[31:1]} and carry-out is operand bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | 32 | Operand to be shifted or rotated |
| kind | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amt | input | 8 | Shift amount, 0 to 255 |
| cin | input | 1 | Carry-in, used by a left shift of zero and by a rotate through carry |
| res | output | 32 | Shifted or rotated result |
| cout | output | 1 | Carry-out |

## Verification
The block holds no state. Any fault in how it decodes the amount or the kind therefore shows on `res` or `cout` in the same cycle as the stimulus.

The fault is confined to a band of amounts:
- the zero amount;
- exactly 32;
- above 32;
- multiples of 32 under rotation.

For that reason the sweep covers every kind, every amount, both carry-in values and a spread of operand patterns. Every band is therefore hit with operands whose edge bits differ.

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [1:0]        kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int LOG_W = $clog2(DATA_W);
  localparam int N_W   = LOG_W + 1;
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);
  localparam logic [1:0] K_LSL = 2'b00;
  localparam logic [1:0] K_LSR = 2'b01;
  localparam logic [1:0] K_ASR = 2'b10;

  logic amt_zero, amt_over;
  assign amt_zero = (amt == '0);
  assign amt_over = (amt > FULL);

  logic [N_W-1:0] n_r, n_asr;
  assign n_r   = amt_zero ? N_W'(DATA_W) : N_W'(amt);
  assign n_asr = (amt_zero || amt_over) ? N_W'(DATA_W) : N_W'(amt);

  logic        [DATA_W:0]   lsl_x, lsr_x;
  logic signed [DATA_W:0]   asr_x;
  logic        [DATA_W-1:0] ror_res;

  assign lsl_x   = {1'b0, opnd} << n_r;
  assign lsr_x   = {opnd, 1'b0} >> n_r;
  assign asr_x   = $signed({opnd, 1'b0}) >>> n_asr;
  assign ror_res = DATA_W'({opnd, opnd} >> amt[LOG_W-1:0]);

  always_comb begin
    case (kind)
      K_LSL: begin
        if (amt_zero)      {cout, res} = {cin, opnd};
        else if (amt_over) {cout, res} = '0;
        else               {cout, res} = lsl_x;
      end
      K_LSR: begin
        if (amt_over) {res, cout} = '0;
        else          {res, cout} = lsr_x;
      end
      K_ASR: {res, cout} = asr_x;
      default: begin
        if (amt_zero) {res, cout} = {cin, opnd};
        else          {cout, res} = {ror_res[DATA_W-1], ror_res};
      end
    endcase
  end
endmodule

module shift_unit_chk #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input logic [DATA_W-1:0] opnd,
  input logic [1:0]        kind,
  input logic [AMT_W-1:0]  amt,
  input logic              cin,
  input logic [DATA_W-1:0] res,
  input logic              cout
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  always_comb begin
    p_lsl_zero_r2: assert (!(kind == 2'b00 && amt == '0) || (res == opnd && cout == cin))
      else $error("lsl by zero must pass through");
    p_lsl_over_r3: assert (!(kind == 2'b00 && amt > FULL) || (res == '0 && !cout))
      else $error("lsl beyond width must clear");
    p_lsr_over_r6: assert (!(kind == 2'b01 && amt > FULL) || (res == '0 && !cout))
      else $error("lsr beyond width must clear");
    p_lsr_full_r5: assert (!(kind == 2'b01 && (amt == '0 || amt == FULL)) || (res == '0 && cout == opnd[DATA_W-1]))
      else $error("lsr by zero or width");
    p_asr_fill_r8: assert (!(kind == 2'b10 && (amt == '0 || amt >= FULL))
                           || (res == {DATA_W{opnd[DATA_W-1]}} && cout == opnd[DATA_W-1]))
      else $error("asr fill");
    p_rrx_r11: assert (!(kind == 2'b11 && amt == '0) || (res == {cin, opnd[DATA_W-1:1]} && cout == opnd[0]))
      else $error("rotate through carry");
    p_ror_carry_r9: assert (!(kind == 2'b11 && amt != '0)
                            || (cout == res[DATA_W-1] && $countones(res) == $countones(opnd)))
      else $error("rotate carry or bit count");
  end
endmodule

bind shift_unit shift_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .opnd(opnd), .kind(kind), .amt(amt), .cin(cin), .res(res), .cout(cout)
);

// File: tb/tb_shift_unit.sv
`timescale 1ns/1ps
module tb_shift_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] opnd;
  logic [1:0]  kind;
  logic [7:0]  amt;
  logic        cin;
  logic [31:0] res;
  logic        cout;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shift_unit dut (.opnd(opnd), .kind(kind), .amt(amt), .cin(cin), .res(res), .cout(cout));

  function automatic logic [32:0] model(input logic [31:0] a, input int k, input int n, input logic ci);
    logic [31:0] r;
    logic c;
    int e;
    r = '0;
    c = 1'b0;
    case (k)
      0: if (n == 0) begin r = a; c = ci; end
         else begin
           for (int i = 0; i < 32; i++) r[i] = (i - n >= 0) ? a[i-n] : 1'b0;
           c = (n <= 32) ? a[32-n] : 1'b0;
         end
      1: begin
           e = (n == 0) ? 32 : n;
           for (int i = 0; i < 32; i++) r[i] = (i + e < 32) ? a[i+e] : 1'b0;
           c = (e <= 32) ? a[e-1] : 1'b0;
         end
      2: begin
           e = (n == 0 || n > 32) ? 32 : n;
           for (int i = 0; i < 32; i++) r[i] = (i + e < 32) ? a[i+e] : a[31];
           c = a[e-1];
         end
      default: if (n == 0) begin r = {ci, a[31:1]}; c = a[0]; end
         else begin
           e = n % 32;
           for (int i = 0; i < 32; i++) r[i] = a[(i+e)%32];
           c = r[31];
         end
    endcase
    return {c, r};
  endfunction

  function automatic string req_of(input int k, input int n);
    case (k)
      0: return (n == 0) ? "R2" : (n <= 32) ? "R1" : "R3";
      1: return (n == 0) ? "R5" : (n <= 32) ? "R4" : "R6";
      2: return (n >= 1 && n < 32) ? "R7" : "R8";
      default: return (n == 0) ? "R11" : (n % 32 == 0) ? "R10" : "R9";
    endcase
  endfunction

  task automatic check(input logic [31:0] a, input int k, input int n, input logic ci,
                       input logic [32:0] exp, input string tag);
    @(negedge clk);
    opnd = a; kind = 2'(k); amt = 8'(n); cin = ci;
    #1;
    n_chk++;
    if ({cout, res} !== exp) begin
      n_bad++;
      $display("FAIL %s: op=%08h kind=%0d amt=%0d cin=%0b got cout=%0b res=%08h exp cout=%0b res=%08h",
               tag, a, k, n, ci, cout, res, exp[32], exp[31:0]);
    end
  endtask

  logic [31:0] pats [16];

  initial begin
    opnd = '0; kind = '0; amt = '0; cin = 1'b0;
    pats[0]  = 32'h0000_0000; pats[1]  = 32'hFFFF_FFFF; pats[2]  = 32'h8000_0000; pats[3]  = 32'h0000_0001;
    pats[4]  = 32'h7FFF_FFFF; pats[5]  = 32'hFFFF_FFFE; pats[6]  = 32'h1234_5678; pats[7]  = 32'hA5F9_6342;
    pats[8]  = 32'h123F_ABCE; pats[9]  = 32'h123F_ABCF; pats[10] = 32'h5555_5555; pats[11] = 32'hAAAA_AAAA;
    pats[12] = 32'h8000_0001; pats[13] = 32'h0000_4001; pats[14] = 32'hFFC0_0000; pats[15] = 32'h0123_0031;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    // reset state: zero inputs give zero outputs (R2 passthrough)
    check(32'h0, 0, 0, 1'b0, 33'h0, "R2 reset");
    check(32'h8000_0000, 0, 1, 1'b0, {1'b1, 32'h0}, "R1");
    check(32'h0000_4001, 0, 17, 1'b0, {1'b0, 32'h8002_0000}, "R1");
    check(32'h0000_4001, 0, 18, 1'b0, {1'b1, 32'h0004_0000}, "R1");
    check(32'hFFFF_FFFF, 1, 0, 1'b0, {1'b1, 32'h0}, "R5");
    check(32'hFFFF_FFFF, 1, 33, 1'b1, {1'b0, 32'h0}, "R6");
    check(32'h8000_0000, 2, 32, 1'b0, {1'b1, 32'hFFFF_FFFF}, "R8");
    check(32'h0123_0031, 2, 3, 1'b0, {1'b0, 32'h0024_6006}, "R7");
    check(32'hA5F9_6342, 3, 17, 1'b0, {1'b1, 32'hB1A1_52FC}, "R9");
    check(32'hFECD_BA12, 3, 32, 1'b0, {1'b1, 32'hFECD_BA12}, "R10");
    check(32'h123F_ABCE, 3, 0, 1'b1, {1'b0, 32'h891F_D5E7}, "R11");
    check(32'h123F_ABCF, 3, 0, 1'b0, {1'b1, 32'h091F_D5E7}, "R11");
    check(32'h0000_0001, 0, 200, 1'b1, 33'h0, "R3");
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 256; n++)
        for (int p = 0; p < 16; p++)
          for (int c = 0; c < 2; c++)
            check(pats[p], k, n, c[0], model(pats[p], k, n, c[0]), req_of(k, n));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule